// File: doc/BRIEF.md
# Indexed Control and Status Register Port

This block gives a host a two-location window into a 128-byte register space. The host first writes a byte index to the index location (`host_sel` low). It then reads or writes the selected byte through the data location (`host_sel` high). Most bytes are plain storage. Four bytes at indices 0x0A through 0x0D hold control and status and behave differently. One has a host-protected update-in-progress bit. One carries a set-mode interlock. Two status bytes cannot be written by the host, and one of them clears itself when read.

A neighbouring timekeeping block signals the start and end of each update through `uip_set` and `uip_clr`. It also raises one-cycle flag strobes for update-ended, alarm and periodic events. Each strobe sets a flag in the status byte at index 0x0C. When the matching enable is on, the strobe also sets the summary interrupt flag. The `irq` output follows that summary flag, and a host read of the status byte drops it. Host reads are combinational from the current state. Every side effect of an access lands at the clock edge that ends the access cycle.

Top module: `regport_top`

## Requirements
- R1: A data-location write is ignored when `host_sel` is 0. A write with `host_sel` 0 loads the low 7 bits of `host_wdata` as the index, and bit 7 is discarded. A read with `host_sel` 0 returns 0xFF.
- R2: With `host_sel` 1, a write stores `host_wdata` at the latched index and a read returns the byte stored there. This holds for every index outside 0x0A to 0x0D.
- R3: Host writes to index 0x0C (status) and to index 0x0D (always reads 0x80) have no effect.
- R4: A host read of index 0x0C returns the current status byte. From the next cycle the byte is 0x00 and `irq` is low, unless a flag strobe arrived in that same cycle.
- R5: A host write to index 0x0A leaves bit 7 (update-in-progress) unchanged and replaces bits 6..0 with the written data.
- R6: A host write to index 0x0B with bit 7 (set mode) high clears bit 7 of index 0x0A. The stored value has bit 4 (update-interrupt enable) forced to 0, and the other bits are stored as written.
- R7: After reset, index 0x0A reads 0x26, 0x0B reads 0x02, 0x0C reads 0x00, 0x0D reads 0x80, and `irq` is low.
- R8: Each strobe sets one bit of index 0x0C: `per_stb` sets bit 6, `alarm_stb` sets bit 5 and `upd_stb` sets bit 4. If the matching enable in index 0x0B is set (bit 6, 5 or 4 respectively), the strobe also sets bit 7 of index 0x0C and `irq` goes high.
- R9: A flag strobe in the same cycle as a host read of index 0x0C survives. The read returns the old value, and the new flag (and the interrupt flag, if enabled) is present afterwards.
- R10: `uip_set` sets bit 7 of index 0x0A only while bit 7 of index 0x0B is clear. `uip_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 selects the index location, 1 the data location |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, side effects at the clock edge |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| per_stb | input | 1 | Periodic event strobe |
| alarm_stb | input | 1 | Alarm match strobe |
| upd_stb | input | 1 | Update-ended strobe |
| uip_set | input | 1 | Update starting |
| uip_clr | input | 1 | Update finished |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume the host never raises `host_wr` and `host_rd` in the same cycle. They also assume `uip_set` and `uip_clr` are never high together. The directed tasks drive one access per cycle and pulse each strobe for a single cycle, so both conditions hold. The clear-on-read and write-protect properties qualify themselves on the absence of flag strobes. Only the race property and the race task combine a status read with a strobe, and they do so on purpose.

// File: rtl/regport_pkg.sv
package regport_pkg;
   localparam int unsigned IDX_CTL_A = 10;
   localparam int unsigned IDX_CTL_B = 11;
   localparam int unsigned IDX_STAT  = 12;
   localparam int unsigned IDX_FIXED = 13;

   localparam int unsigned A_BUSY  = 7;
   localparam int unsigned B_HOLD  = 7;
   localparam int unsigned B_PEN   = 6;
   localparam int unsigned B_AEN   = 5;
   localparam int unsigned B_UEN   = 4;

   localparam int unsigned C_INT   = 7;
   localparam int unsigned C_PER   = 6;
   localparam int unsigned C_ALM   = 5;
   localparam int unsigned C_UPD   = 4;

   localparam logic [7:0] A_INIT = 8'h26;
   localparam logic [7:0] B_INIT = 8'h02;
   localparam logic [7:0] C_INIT = 8'h00;
   localparam logic [7:0] D_VAL  = 8'h80;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } flag_stb_t;
endpackage

// File: rtl/regport_index.sv
module regport_index #(
   parameter int IDX_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [IDX_W-1:0]  idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (load)
         idx <= din[IDX_W-1:0];
   end
endmodule

// File: rtl/regport_store.sv
module regport_store #(
   parameter int IDX_W       = 7,
   parameter int DATA_W      = 8,
   parameter bit RESET_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (RESET_STORE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++)
                  mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_plain
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we)
               mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[addr];
endmodule

// File: rtl/regport_ctrl.sv
module regport_ctrl
   import regport_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_a,
   input  logic      wr_b,
   input  logic      rd_c,
   input  logic [7:0] wdata,
   input  flag_stb_t stb,
   input  logic      busy_set,
   input  logic      busy_clr,
   output logic [7:0] reg_a,
   output logic [7:0] reg_b,
   output logic [7:0] reg_c
);
   logic       busy_n;
   logic [6:0] a_low_n;
   logic [7:0] b_n;
   logic [7:0] c_base;
   logic [7:0] c_set;
   logic       hold_enter;

   assign hold_enter = wr_b && wdata[B_HOLD];

   always_comb begin
      busy_n = reg_a[A_BUSY];
      if (busy_set && !reg_b[B_HOLD])
         busy_n = 1'b1;
      if (busy_clr)
         busy_n = 1'b0;
      if (hold_enter)
         busy_n = 1'b0;
      a_low_n = wr_a ? wdata[6:0] : reg_a[6:0];
   end

   always_comb begin
      b_n = reg_b;
      if (wr_b) begin
         b_n = wdata;
         if (wdata[B_HOLD])
            b_n[B_UEN] = 1'b0;
      end
   end

   always_comb begin
      c_base = rd_c ? 8'h00 : reg_c;
      c_set  = 8'h00;
      c_set[C_PER] = stb.per;
      c_set[C_ALM] = stb.alm;
      c_set[C_UPD] = stb.upd;
      c_set[C_INT] = (stb.per && reg_b[B_PEN]) ||
                     (stb.alm && reg_b[B_AEN]) ||
                     (stb.upd && reg_b[B_UEN]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= A_INIT;
         reg_b <= B_INIT;
         reg_c <= C_INIT;
      end else begin
         reg_a <= {busy_n, a_low_n};
         reg_b <= b_n;
         reg_c <= c_base | c_set;
      end
   end
endmodule

// File: rtl/regport_top.sv
module regport_top
   import regport_pkg::*;
#(
   parameter int IDX_W       = 7,
   parameter int DATA_W      = 8,
   parameter bit RESET_STORE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              per_stb,
   input  logic              alarm_stb,
   input  logic              upd_stb,
   input  logic              uip_set,
   input  logic              uip_clr,
   output logic              irq
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("regport_top: DATA_W must be 8");
      end
      if (IDX_W < 4 || IDX_W >= DATA_W) begin : g_bad_idx
         $error("regport_top: IDX_W must be 4..DATA_W-1");
      end
   endgenerate

   localparam logic [IDX_W-1:0] K_A = IDX_W'(IDX_CTL_A);
   localparam logic [IDX_W-1:0] K_B = IDX_W'(IDX_CTL_B);
   localparam logic [IDX_W-1:0] K_C = IDX_W'(IDX_STAT);
   localparam logic [IDX_W-1:0] K_D = IDX_W'(IDX_FIXED);

   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] store_rd;
   logic [7:0]        reg_a, reg_b, reg_c;
   logic              data_wr, data_rd;
   logic              hit_a, hit_b, hit_c, hit_d, hit_ctl;
   flag_stb_t         stb;

   assign data_wr = host_wr && host_sel;
   assign data_rd = host_rd && host_sel;
   assign hit_a   = (idx_q == K_A);
   assign hit_b   = (idx_q == K_B);
   assign hit_c   = (idx_q == K_C);
   assign hit_d   = (idx_q == K_D);
   assign hit_ctl = hit_a || hit_b || hit_c || hit_d;
   assign stb     = '{per: per_stb, alm: alarm_stb, upd: upd_stb};

   regport_index #(.IDX_W(IDX_W), .DATA_W(DATA_W)) index_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (host_wr && !host_sel),
      .din  (host_wdata),
      .idx  (idx_q)
   );

   regport_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .RESET_STORE(RESET_STORE)) store_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (data_wr && !hit_ctl),
      .addr (idx_q),
      .wdata(host_wdata),
      .rdata(store_rd)
   );

   regport_ctrl ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_a    (data_wr && hit_a),
      .wr_b    (data_wr && hit_b),
      .rd_c    (data_rd && hit_c),
      .wdata   (host_wdata),
      .stb     (stb),
      .busy_set(uip_set),
      .busy_clr(uip_clr),
      .reg_a   (reg_a),
      .reg_b   (reg_b),
      .reg_c   (reg_c)
   );

   always_comb begin
      if (!host_sel)
         host_rdata = '1;
      else if (hit_a)
         host_rdata = reg_a;
      else if (hit_b)
         host_rdata = reg_b;
      else if (hit_c)
         host_rdata = reg_c;
      else if (hit_d)
         host_rdata = D_VAL;
      else
         host_rdata = store_rd;
   end

   assign irq = reg_c[C_INT];
endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
   parameter int IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel,
   input logic             host_wr,
   input logic             host_rd,
   input logic [7:0]       host_wdata,
   input logic [7:0]       host_rdata,
   input logic [IDX_W-1:0] idx,
   input logic [7:0]       reg_a,
   input logic [7:0]       reg_b,
   input logic [7:0]       reg_c,
   input logic             per_stb,
   input logic             alarm_stb,
   input logic             upd_stb,
   input logic             uip_set,
   input logic             uip_clr,
   input logic             irq
);
   logic no_stb;
   assign no_stb = !per_stb && !alarm_stb && !upd_stb;

   // R1
   idx_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_sel) |-> host_rdata == 8'hFF);

   // R3
   stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel && idx == IDX_W'(12) && no_stb) |=> reg_c == $past(reg_c));

   // R4
   stat_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel && idx == IDX_W'(12) && no_stb) |=> (reg_c == 8'h00 && !irq));

   // R5
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel && idx == IDX_W'(10) && !uip_set && !uip_clr)
      |=> (reg_a[7] == $past(reg_a[7]) && reg_a[6:0] == $past(host_wdata[6:0])));

   // R6
   hold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel && idx == IDX_W'(11) && host_wdata[7])
      |=> (!reg_a[7] && !reg_b[4] && reg_b[7]));

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((per_stb && reg_b[6]) || (alarm_stb && reg_b[5]) ||
                           (upd_stb && reg_b[4])));

   // R9
   race_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel && idx == IDX_W'(12) && per_stb) |=> reg_c[6]);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_b[7] && !reg_a[7]) |=> !reg_a[7]);
endmodule

bind regport_top regport_chk #(.IDX_W(IDX_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_sel  (host_sel),
   .host_wr   (host_wr),
   .host_rd   (host_rd),
   .host_wdata(host_wdata),
   .host_rdata(host_rdata),
   .idx       (idx_q),
   .reg_a     (reg_a),
   .reg_b     (reg_b),
   .reg_c     (reg_c),
   .per_stb   (per_stb),
   .alarm_stb (alarm_stb),
   .upd_stb   (upd_stb),
   .uip_set   (uip_set),
   .uip_clr   (uip_clr),
   .irq       (irq)
);

// File: tb/regport_top_tb_top.sv
`timescale 1ns/100ps
module regport_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       per_stb = 1'b0, alarm_stb = 1'b0, upd_stb = 1'b0;
   logic       uip_set = 1'b0, uip_clr = 1'b0;
   logic       irq;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   regport_top dut_i (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .per_stb(per_stb), .alarm_stb(alarm_stb), .upd_stb(upd_stb),
      .uip_set(uip_set), .uip_clr(uip_clr), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic set_idx(input logic [7:0] v);
      @(negedge clk); host_sel = 1'b0; host_wr = 1'b1; host_wdata = v;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic put(input logic [7:0] v);
      @(negedge clk); host_sel = 1'b1; host_wr = 1'b1; host_wdata = v;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic get(output logic [7:0] v);
      @(negedge clk); host_sel = 1'b1; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] i, input logic [7:0] v);
      set_idx(i); put(v);
   endtask

   task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
      set_idx(i); get(v);
   endtask

   task automatic pulse(input bit p, input bit a, input bit u, input bit s, input bit c);
      @(negedge clk);
      per_stb = p; alarm_stb = a; upd_stb = u; uip_set = s; uip_clr = c;
      @(negedge clk);
      per_stb = 0; alarm_stb = 0; upd_stb = 0; uip_set = 0; uip_clr = 0;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      chk("R7 irq", {7'b0, irq}, 8'h00);
      rd_reg(8'h0A, v); chk("R7 regA", v, 8'h26);
      rd_reg(8'h0B, v); chk("R7 regB", v, 8'h02);
      rd_reg(8'h0C, v); chk("R7 regC", v, 8'h00);
      rd_reg(8'h0D, v); chk("R7 regD", v, 8'h80);
   endtask

   task automatic t_index;
      logic [7:0] v;
      wr_reg(8'h8F, 8'h5A);
      rd_reg(8'h0F, v); chk("R1 index masked", v, 8'h5A);
      @(negedge clk); host_sel = 1'b0; host_rd = 1'b1;
      #1 v = host_rdata;
      @(negedge clk); host_rd = 1'b0;
      chk("R1 index read", v, 8'hFF);
      wr_reg(8'h20, 8'h11);
      wr_reg(8'h7F, 8'h22);
      wr_reg(8'h00, 8'h33);
      rd_reg(8'h20, v); chk("R2 idx20", v, 8'h11);
      rd_reg(8'h7F, v); chk("R2 idx7F", v, 8'h22);
      rd_reg(8'h00, v); chk("R2 idx00", v, 8'h33);
   endtask

   task automatic t_readonly;
      logic [7:0] v;
      wr_reg(8'h0C, 8'hFF);
      chk("R3 irq after C write", {7'b0, irq}, 8'h00);
      rd_reg(8'h0C, v); chk("R3 regC", v, 8'h00);
      wr_reg(8'h0D, 8'h00);
      rd_reg(8'h0D, v); chk("R3 regD", v, 8'h80);
   endtask

   task automatic t_reg_a;
      logic [7:0] v;
      wr_reg(8'h0A, 8'hAB);
      rd_reg(8'h0A, v); chk("R5 busy kept low", v, 8'h2B);
      pulse(0, 0, 0, 1, 0);
      rd_reg(8'h0A, v); chk("R10 busy set", v, 8'hAB);
      wr_reg(8'h0A, 8'h05);
      rd_reg(8'h0A, v); chk("R5 busy kept high", v, 8'h85);
      pulse(0, 0, 0, 0, 1);
      rd_reg(8'h0A, v); chk("R10 busy clr", v, 8'h05);
   endtask

   task automatic t_hold;
      logic [7:0] v;
      wr_reg(8'h0B, 8'h12);
      rd_reg(8'h0B, v); chk("R6 plain B write", v, 8'h12);
      pulse(0, 0, 0, 1, 0);
      wr_reg(8'h0B, 8'h92);
      rd_reg(8'h0B, v); chk("R6 B update enable forced off", v, 8'h82);
      rd_reg(8'h0A, v); chk("R6 busy cleared", v, 8'h05);
      pulse(0, 0, 0, 1, 0);
      rd_reg(8'h0A, v); chk("R10 set ignored in hold", v, 8'h05);
      wr_reg(8'h0B, 8'h02);
   endtask

   task automatic t_flags;
      logic [7:0] v;
      pulse(1, 0, 0, 0, 0);
      chk("R8 per no enable irq", {7'b0, irq}, 8'h00);
      rd_reg(8'h0C, v); chk("R8 per flag", v, 8'h40);
      wr_reg(8'h0B, 8'h42);
      pulse(1, 0, 0, 0, 0);
      chk("R8 per irq", {7'b0, irq}, 8'h01);
      rd_reg(8'h0C, v); chk("R4 read value", v, 8'hC0);
      chk("R4 irq dropped", {7'b0, irq}, 8'h00);
      rd_reg(8'h0C, v); chk("R4 cleared", v, 8'h00);
      wr_reg(8'h0B, 8'h22);
      pulse(0, 1, 0, 0, 0);
      chk("R8 alarm irq", {7'b0, irq}, 8'h01);
      rd_reg(8'h0C, v); chk("R8 alarm flags", v, 8'hA0);
      wr_reg(8'h0B, 8'h12);
      pulse(0, 0, 1, 0, 0);
      rd_reg(8'h0C, v); chk("R8 update flags", v, 8'h90);
   endtask

   task automatic t_race;
      logic [7:0] v;
      wr_reg(8'h0B, 8'h42);
      pulse(1, 0, 0, 0, 0);
      set_idx(8'h0C);
      @(negedge clk); host_sel = 1'b1; host_rd = 1'b1; alarm_stb = 1'b1;
      #1 v = host_rdata;
      @(negedge clk); host_rd = 1'b0; alarm_stb = 1'b0;
      chk("R9 race read value", v, 8'hC0);
      chk("R9 irq low after race", {7'b0, irq}, 8'h00);
      get(v); chk("R9 alarm survives", v, 8'h20);
      pulse(1, 0, 0, 0, 0);
      @(negedge clk); host_sel = 1'b1; host_rd = 1'b1; per_stb = 1'b1;
      #1 v = host_rdata;
      @(negedge clk); host_rd = 1'b0; per_stb = 1'b0;
      chk("R9 race read value 2", v, 8'hC0);
      chk("R9 irq kept", {7'b0, irq}, 8'h01);
      get(v); chk("R9 periodic survives", v, 8'hC0);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_index();
      t_readonly();
      t_reg_a();
      t_hold();
      t_flags();
      t_race();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end
endmodule